// File: doc/BRIEF.md
# Element-Width Configurable Saturating Adder

This block adds two integer vector elements whose size is picked on every operation: 8, 16, 32 or 64 bits. The element is taken from the low bits of each 64-bit operand word. A per-operation flag says whether the operands are read as two's-complement or as unsigned numbers. The true sum is formed with headroom beyond the element, so it is exact, and only then is it clamped.

There are three clamp choices. With no saturation the result wraps modulo 2^w. With signed saturation it is held to the signed range of the element. With unsigned saturation it is held to the unsigned range, so a negative true sum becomes zero. The clamp choice is independent of how the operands were read.

A clamp never traps. Instead it sets a sticky overflow summary flag, which stays set until a clear strobe is given. The result is registered, zero above the element, and comes with a valid strobe one cycle after the input strobe.

Top module: `ewsat_add`

## Requirements
- R1: `ew_sel` picks the element width w: 2'b00 = 8, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64. Only operand bits [w-1:0] take part in the add, and the operation is an add at every width.
- R2: With `in_signed` = 1 each operand element is read as two's complement. With `in_signed` = 0 it is read as unsigned. The sum is exact before any clamp, so an unsigned 8-bit 200 stays +200.
- R3: With `sat_mode` 2'b00, or the spare code 2'b11, the result is the exact sum modulo 2^w. In these modes `sum_ovf` keeps its value.
- R4: With `sat_mode` 2'b01 the result is clamped to the range -2^(w-1) to 2^(w-1)-1 and written as a w-bit two's-complement pattern.
- R5: With `sat_mode` 2'b10 a negative exact sum gives 0, and a sum above 2^w-1 gives w ones. This holds even when the operands are signed.
- R6: `result` bits [63:w] are always zero when `out_valid` is high.
- R7: `out_valid` rises exactly one cycle after `in_valid`. `result` then holds the value for that operation. In a cycle after one with `in_valid` low, `out_valid` is low and `result` keeps its previous value.
- R8: `sum_ovf` is set at the same edge that registers a clamped result. It stays set until `flag_clr` is sampled high. If a clamp and a clear happen in the same cycle, the flag ends up set.
- R9: In a saturating mode, an exact sum inside the range gives that sum unchanged and does not set `sum_ovf`.
- R10: After reset, `out_valid`, `result` and `sum_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | First operand word |
| op_b | input | 64 | Second operand word |
| ew_sel | input | 2 | Element width code |
| in_signed | input | 1 | Operands are two's complement |
| sat_mode | input | 2 | Clamp choice: off, signed, unsigned, spare (as off) |
| flag_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Clamped sum, zero above the element |
| sum_ovf | output | 1 | Sticky overflow summary flag |

## Verification
Every result, every `out_valid` pulse and every change of `sum_ovf` appears at the first rising edge after the strobe or clear that causes it. The bench drives inputs on a falling edge and reads the outputs on the next falling edge, half a cycle after the registering edge. Back-to-back operations are read one falling edge apart, each in its own cycle. Idle and clear-only cycles are read one falling edge later to confirm the held result and the flag state.

// File: rtl/ewsat_pkg.sv
package ewsat_pkg;

    typedef enum logic [1:0] {
        SAT_OFF = 2'b00,
        SAT_SGN = 2'b01,
        SAT_UNS = 2'b10,
        SAT_RSV = 2'b11
    } sat_mode_e;

    // number of selectable element widths
    localparam int unsigned EW_CNT = 4;

    // width of lane k: the full word halved (EW_CNT-1-k) times
    function automatic int unsigned lane_width(int unsigned data_w, int unsigned k);
        return data_w >> (EW_CNT - 1 - k);
    endfunction

endpackage

// File: rtl/ewsat_widen.sv
module ewsat_widen
    import ewsat_pkg::*;
#(
    parameter  int unsigned DATA_W = 64,
    localparam int unsigned EXT_W  = DATA_W + 2,
    localparam int unsigned SEL_W  = $clog2(EW_CNT)
) (
    input  logic [DATA_W-1:0]       op_i,
    input  logic [SEL_W-1:0]        ew_i,
    input  logic                    signed_i,
    output logic signed [EXT_W-1:0] ext_o
);

    logic [EXT_W-1:0] lane_ext [EW_CNT];

    // one widened copy per element width; the selector picks one
    for (genvar k = 0; k < EW_CNT; k++) begin : g_lane
        localparam int unsigned W = lane_width(DATA_W, k);
        logic fill;
        assign fill        = signed_i & op_i[W-1];
        assign lane_ext[k] = {{(EXT_W-W){fill}}, op_i[W-1:0]};
    end

    assign ext_o = $signed(lane_ext[ew_i]);

endmodule

// File: rtl/ewsat_clamp.sv
module ewsat_clamp
    import ewsat_pkg::*;
#(
    parameter  int unsigned DATA_W = 64,
    localparam int unsigned EXT_W  = DATA_W + 2,
    localparam int unsigned SEL_W  = $clog2(EW_CNT)
) (
    input  logic signed [EXT_W-1:0] sum_i,
    input  logic [SEL_W-1:0]        ew_i,
    input  sat_mode_e               mode_i,
    output logic [DATA_W-1:0]       res_o,
    output logic                    hit_o
);

    logic signed [EXT_W-1:0] smax [EW_CNT];
    logic signed [EXT_W-1:0] smin [EW_CNT];
    logic signed [EXT_W-1:0] umax [EW_CNT];

    // range bounds for each width, laid out at full precision
    for (genvar k = 0; k < EW_CNT; k++) begin : g_bound
        localparam int unsigned W = lane_width(DATA_W, k);
        assign smax[k] = $signed({{(EXT_W-W+1){1'b0}}, {(W-1){1'b1}}});
        assign smin[k] = $signed({{(EXT_W-W+1){1'b1}}, {(W-1){1'b0}}});
        assign umax[k] = $signed({{(EXT_W-W){1'b0}}, {W{1'b1}}});
    end

    logic signed [EXT_W-1:0] smax_sel, smin_sel, umax_sel;
    logic [DATA_W-1:0]       mask;
    logic                    above_s, below_s, above_u, below_u;

    always_comb begin
        smax_sel = smax[ew_i];
        smin_sel = smin[ew_i];
        umax_sel = umax[ew_i];
        mask     = umax_sel[DATA_W-1:0];
        above_s  = sum_i > smax_sel;
        below_s  = sum_i < smin_sel;
        above_u  = sum_i > umax_sel;
        below_u  = sum_i[EXT_W-1];

        res_o = sum_i[DATA_W-1:0] & mask;
        hit_o = 1'b0;
        case (mode_i)
            SAT_SGN: begin
                if (above_s) begin
                    res_o = smax_sel[DATA_W-1:0];
                    hit_o = 1'b1;
                end else if (below_s) begin
                    res_o = smin_sel[DATA_W-1:0] & mask;
                    hit_o = 1'b1;
                end
            end
            SAT_UNS: begin
                if (below_u) begin
                    res_o = '0;
                    hit_o = 1'b1;
                end else if (above_u) begin
                    res_o = mask;
                    hit_o = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        AST_UNS_NEG_TO_ZERO: assert (!(mode_i == SAT_UNS && sum_i < 0) || (res_o == '0 && hit_o)); // R5
        AST_OFF_NEVER_HITS: assert (!(mode_i == SAT_OFF || mode_i == SAT_RSV) || !hit_o); // R3
    end

endmodule

// File: rtl/ewsat_add.sv
module ewsat_add
    import ewsat_pkg::*;
#(
    parameter  int unsigned DATA_W = 64,
    localparam int unsigned EXT_W  = DATA_W + 2,
    localparam int unsigned SEL_W  = $clog2(EW_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [SEL_W-1:0]  ew_sel,
    input  logic              in_signed,
    input  logic [1:0]        sat_mode,
    input  logic              flag_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sum_ovf
);

    typedef struct packed {
        logic              vld;
        logic              ovf;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    logic signed [EXT_W-1:0] a_ext, b_ext, sum_ext;
    logic [DATA_W-1:0]       clamp_res;
    logic                    clamp_hit;
    sat_mode_e               mode;

    assign mode = sat_mode_e'(sat_mode);

    ewsat_widen #(.DATA_W(DATA_W)) u_widen_a (
        .op_i     (op_a),
        .ew_i     (ew_sel),
        .signed_i (in_signed),
        .ext_o    (a_ext)
    );

    ewsat_widen #(.DATA_W(DATA_W)) u_widen_b (
        .op_i     (op_b),
        .ew_i     (ew_sel),
        .signed_i (in_signed),
        .ext_o    (b_ext)
    );

    // exact sum: two extra bits hold every signed or unsigned pair
    assign sum_ext = a_ext + b_ext;

    ewsat_clamp #(.DATA_W(DATA_W)) u_clamp (
        .sum_i  (sum_ext),
        .ew_i   (ew_sel),
        .mode_i (mode),
        .res_o  (clamp_res),
        .hit_o  (clamp_hit)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = clamp_res;
        end
        state_d.ovf = (state_q.ovf & ~flag_clr) | (in_valid & clamp_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
    assign sum_ovf   = state_q.ovf;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_ovf && !flag_clr) |=> sum_ovf); // R8
    AST_PLAIN_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && (!in_valid || (sat_mode != SAT_SGN && sat_mode != SAT_UNS)))
        |=> $stable(sum_ovf)); // R3
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(ew_sel) == '0) |-> (result[DATA_W-1:DATA_W/8] == '0)); // R6

endmodule

// File: tb/sim_ewsat_add.sv
`timescale 1ns/1ps
module sim_ewsat_add;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  ew;
        logic        sg;
        logic [1:0]  md;
        logic [63:0] exp;
        logic        hit;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{64'h7F, 64'h01, 2'd0, 1'b1, 2'd0, 64'h80, 1'b0},                              // R3 wrap
        '{64'h7F, 64'h01, 2'd0, 1'b1, 2'd1, 64'h7F, 1'b1},                              // R4 high
        '{64'h80, 64'hFF, 2'd0, 1'b1, 2'd1, 64'h80, 1'b1},                              // R4 low
        '{64'hFF, 64'h01, 2'd0, 1'b0, 2'd2, 64'hFF, 1'b1},                              // R5 high
        '{64'hFE, 64'h01, 2'd0, 1'b1, 2'd2, 64'h00, 1'b1},                              // R5 negative
        '{64'hC8, 64'h00, 2'd0, 1'b0, 2'd1, 64'h7F, 1'b1},                              // R2 unsigned read
        '{64'hFFFF_FFFF_FFFF_7000, 64'h1234_0000_0000_1000, 2'd1, 1'b1, 2'd1, 64'h7FFF, 1'b1}, // R1 R6
        '{64'hABCD_0000_FFFF_FFFF, 64'h5555_0000_0000_0002, 2'd2, 1'b0, 2'd0, 64'h1, 1'b0},    // R1 R3
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 1'b1, 2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1},  // R4 64
        '{64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 2'd1, 64'h8000_0000_0000_0000, 1'b1}, // R4 64
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}, // R5 64
        '{64'h8000_0000_0000_0000, 64'h1, 2'd3, 1'b1, 2'd2, 64'h0, 1'b1},               // R5 64 negative
        '{64'hFFFF_FFFE, 64'h5, 2'd2, 1'b1, 2'd1, 64'h3, 1'b0},                          // R9
        '{64'hF0, 64'h20, 2'd0, 1'b0, 2'd3, 64'h10, 1'b0},                               // R3 spare code
        '{64'h1234, 64'h0001, 2'd1, 1'b0, 2'd2, 64'h1235, 1'b0},                         // R9
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 1'b1, 2'd0, 64'h8000_0000_0000_0000, 1'b0}   // R3 64
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  ew_sel = '0;
    logic        in_signed = 1'b0;
    logic [1:0]  sat_mode = '0;
    logic        flag_clr = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        sum_ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ewsat_add u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .ew_sel(ew_sel), .in_signed(in_signed), .sat_mode(sat_mode), .flag_clr(flag_clr),
        .out_valid(out_valid), .result(result), .sum_ovf(sum_ovf)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic clr);
        in_valid  = 1'b1;
        op_a      = v.a;
        op_b      = v.b;
        ew_sel    = v.ew;
        in_signed = v.sg;
        sat_mode  = v.md;
        flag_clr  = clr;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R10 result", result, 64'd0);
        chk("R10 sum_ovf", {63'd0, sum_ovf}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table: each row clears the flag in its own cycle, so the flag shows that row's clamp
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            idle();
            chk($sformatf("R1 R2 table row %0d result", i), result, VECS[i].exp);
            chk($sformatf("R7 table row %0d valid", i), {63'd0, out_valid}, 64'd1);
            chk($sformatf("R8 table row %0d flag", i), {63'd0, sum_ovf}, {63'd0, VECS[i].hit});
        end

        // R7 idle cycle: valid drops, result holds
        @(negedge clk);
        chk("R7 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R7 idle hold", result, VECS[NV-1].exp);

        // R8 sticky: clamp without clear, then non-clamping ops keep it
        drive(VECS[1], 1'b0);
        @(negedge clk);
        drive(VECS[12], 1'b0);
        chk("R8 set", {63'd0, sum_ovf}, 64'd1);
        @(negedge clk);
        drive(VECS[0], 1'b0);
        chk("R9 in range result", result, 64'h3);
        chk("R8 kept by in-range op", {63'd0, sum_ovf}, 64'd1);
        @(negedge clk);
        idle();
        chk("R7 back-to-back result", result, 64'h80);
        chk("R3 off mode keeps flag", {63'd0, sum_ovf}, 64'd1);
        repeat (3) @(negedge clk);
        chk("R8 held while idle", {63'd0, sum_ovf}, 64'd1);

        // R8 clear on its own
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R8 cleared", {63'd0, sum_ovf}, 64'd0);
        chk("R7 clear leaves result", result, 64'h80);
        chk("R7 clear no valid", {63'd0, out_valid}, 64'd0);

        // R6 narrow width with dirty upper operand bits
        drive('{64'hFFFF_FFFF_FFFF_FF05, 64'hAAAA_AAAA_AAAA_AA03, 2'd0, 1'b0, 2'd0, 64'h08, 1'b0}, 1'b0);
        @(negedge clk);
        idle();
        chk("R6 upper zero", result, 64'h08);
        chk("R3 flag unchanged", {63'd0, sum_ovf}, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule